// File: doc/BRIEF.md
# Read-after-write interlock for a forwarding-free five-stage pipeline

This block decides, every cycle, whether the instruction sitting in decode may move on. The pipeline it serves runs fetch, decode, execute, memory and write-back in order and has no bypass paths. Operands are read from the register file in decode and results are written there in write-back. A consumer that reads a register still being produced by the instruction in execute (one slot ahead) or in memory (two slots ahead) would read a stale value. The unit finds such pairs and stalls the front of the pipeline.

While a stall is active, the unit holds the program counter and the fetch/decode register, and it replaces the control word entering the decode/execute register with all zeros. That zero word is a bubble: it enables no register write and no memory access. A producer three slots ahead needs no stall, because the register file writes on the falling edge and the decode read comes after it. That producer is not presented to the unit at all. Pairs that are read-after-read, write-after-read or write-after-write never stall.

A consumer right behind its producer is held for two cycles, because the producer must leave both execute and memory before the stall ends. The unit is purely a decision and steering path. The register file, the ALU and the fetch logic sit outside it.

Top module: `raw_stall_unit`

## Requirements
- R1: When a used decode source is nonzero and equals the execute-stage destination whose write enable is 1, pc_write and ifid_write are 0 and bubble_sel is 1 in the same cycle.
- R2: When a used decode source is nonzero and equals the memory-stage destination whose write enable is 1, the same stall as in R1 is raised.
- R3: When no used source matches an enabled execute or memory destination, pc_write and ifid_write are 1, bubble_sel is 0 and idex_ctrl equals id_ctrl.
- R4: A source specifier of 0 never causes a stall, even when a producer writes register 0.
- R5: A producer whose write enable is 0 never causes a stall, whatever its destination specifier.
- R6: A source whose use flag is 0 is not compared, so a one-source instruction stalls only on its used source.
- R7: When bubble_sel is 1, idex_ctrl is all zeros, which clears every write-enable and memory-control bit of the injected bubble.
- R8: A consumer directly behind its producer stalls for exactly two cycles. In the first cycle the producer is in execute. In the second it has moved to memory with a bubble behind it. In the third the stall is gone.
- R9: While rst is 1, pc_write and ifid_write are 1 and idex_ctrl is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst | input | 1 | Synchronous active-high reset; flushes the decode/execute control word |
| id_src_a | input | AW | First source register specifier of the decode instruction |
| id_src_a_used | input | 1 | First source is read by the decode instruction |
| id_src_b | input | AW | Second source register specifier of the decode instruction |
| id_src_b_used | input | 1 | Second source is read (0 for immediate forms) |
| ex_dst | input | AW | Destination specifier of the instruction in execute |
| ex_wen | input | 1 | Instruction in execute writes a register |
| mem_dst | input | AW | Destination specifier of the instruction in memory |
| mem_wen | input | 1 | Instruction in memory writes a register |
| id_ctrl | input | CW | Control word decoded for the decode instruction |
| pc_write | output | 1 | Program counter may advance |
| ifid_write | output | 1 | Fetch/decode register may load |
| bubble_sel | output | 1 | Decode/execute register receives a bubble |
| idex_ctrl | output | CW | Control word to load into the decode/execute register |

## Verification
Every result of this unit is combinational: it is due in the same cycle as the specifiers that cause it, with no register in between. The bench therefore changes inputs on the falling clock edge and compares outputs a few nanoseconds later, well before the next rising edge. The two-cycle stall of R8 follows a bench-driven pipeline shift. Each cycle's inputs are derived from the previous cycle's stall decision, and the expected stall is checked again in each of the three cycles.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int NUM_SRC  = 2;
  localparam int NUM_PROD = 2;

  typedef struct packed {
    logic pc_we;
    logic ifid_we;
    logic bubble;
  } stall_dec_t;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] src,
  input  logic          src_used,
  input  logic [AW-1:0] dst,
  input  logic          dst_wen,
  output logic          hit
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  always_comb begin
    hit = src_used && dst_wen && (src != ZERO_REG) && (src == dst);
  end

  // R4
  zero_reg_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (src == ZERO_REG) |-> !hit);
endmodule

// File: rtl/hz_bubble_mux.sv
module hz_bubble_mux #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bubble,
  input  logic [CW-1:0] ctrl_in,
  output logic [CW-1:0] ctrl_out
);
  always_comb begin
    ctrl_out = bubble ? '0 : ctrl_in;
  end

  // R7
  bubble_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bubble |-> (ctrl_out == '0));
  // R3
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    !bubble |-> (ctrl_out == ctrl_in));
endmodule

// File: rtl/raw_stall_unit.sv
module raw_stall_unit
  import hz_pkg::*;
#(
  parameter int AW = 5,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] id_src_a,
  input  logic          id_src_a_used,
  input  logic [AW-1:0] id_src_b,
  input  logic          id_src_b_used,
  input  logic [AW-1:0] ex_dst,
  input  logic          ex_wen,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_wen,
  input  logic [CW-1:0] id_ctrl,
  output logic          pc_write,
  output logic          ifid_write,
  output logic          bubble_sel,
  output logic [CW-1:0] idex_ctrl
);
  logic [AW-1:0] src_vec  [NUM_SRC];
  logic          src_use  [NUM_SRC];
  logic [AW-1:0] prod_dst [NUM_PROD];
  logic          prod_wen [NUM_PROD];
  logic [NUM_SRC*NUM_PROD-1:0] hits;
  logic          raw_hit;
  logic          flush;
  stall_dec_t    dec;

  always_comb begin
    src_vec[0]  = id_src_a;   src_use[0]  = id_src_a_used;
    src_vec[1]  = id_src_b;   src_use[1]  = id_src_b_used;
    prod_dst[0] = ex_dst;     prod_wen[0] = ex_wen;
    prod_dst[1] = mem_dst;    prod_wen[1] = mem_wen;
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
      hz_src_match #(.AW(AW)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .src      (src_vec[s]),
        .src_used (src_use[s]),
        .dst      (prod_dst[p]),
        .dst_wen  (prod_wen[p]),
        .hit      (hits[s*NUM_PROD+p])
      );
    end
  end

  always_comb begin
    raw_hit     = |hits;
    dec.pc_we   = rst || !raw_hit;
    dec.ifid_we = rst || !raw_hit;
    dec.bubble  = !rst && raw_hit;
    flush       = rst || raw_hit;
  end

  assign pc_write   = dec.pc_we;
  assign ifid_write = dec.ifid_we;
  assign bubble_sel = dec.bubble;

  hz_bubble_mux #(.CW(CW)) u_mux (
    .clk      (clk),
    .rst      (rst),
    .bubble   (flush),
    .ctrl_in  (id_ctrl),
    .ctrl_out (idex_ctrl)
  );

  // R1
  ex_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_wen && id_src_a_used && id_src_a != '0 && id_src_a == ex_dst)
      |-> (!pc_write && !ifid_write && bubble_sel));
  // R2
  mem_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wen && id_src_b_used && id_src_b != '0 && id_src_b == mem_dst)
      |-> (!pc_write && !ifid_write && bubble_sel));
  // R5
  no_writer_chk: assert property (@(posedge clk) disable iff (rst)
    (!ex_wen && !mem_wen) |-> (pc_write && !bubble_sel));
  // R6
  no_reader_chk: assert property (@(posedge clk) disable iff (rst)
    (!id_src_a_used && !id_src_b_used) |-> (ifid_write && !bubble_sel));
endmodule

// File: tb/sim_raw_stall_unit.sv
module sim_raw_stall_unit;
  localparam int AW = 5;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] sa = '0, sb = '0, exd = '0, memd = '0;
  logic sau = 1'b0, sbu = 1'b0, exw = 1'b0, memw = 1'b0;
  logic [CW-1:0] ctl = '0;
  logic pcw, ifw, bub;
  logic [CW-1:0] idx;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  raw_stall_unit #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst(rst),
    .id_src_a(sa), .id_src_a_used(sau),
    .id_src_b(sb), .id_src_b_used(sbu),
    .ex_dst(exd), .ex_wen(exw),
    .mem_dst(memd), .mem_wen(memw),
    .id_ctrl(ctl),
    .pc_write(pcw), .ifid_write(ifw), .bubble_sel(bub), .idex_ctrl(idx)
  );

  function automatic bit match(logic [AW-1:0] s, logic u, logic [AW-1:0] d, logic w);
    return u && w && (s != 0) && (s == d);
  endfunction

  function automatic bit exp_stall();
    return match(sa, sau, exd, exw) || match(sb, sbu, exd, exw) ||
           match(sa, sau, memd, memw) || match(sb, sbu, memd, memw);
  endfunction

  task automatic check(string tag);
    logic st;
    logic [CW-1:0] ec;
    st = !rst && exp_stall();
    ec = (rst || st) ? '0 : ctl;
    n_chk++;
    if (pcw !== !st || ifw !== !st || bub !== st || idx !== ec) begin
      n_bad++;
      $display("FAIL %s: got pc=%0b ifid=%0b bub=%0b ctrl=%h exp pc=%0b ifid=%0b bub=%0b ctrl=%h",
               tag, pcw, ifw, bub, idx, !st, !st, st, ec);
    end
  endtask

  task automatic step(string tag);
    #5 check(tag);
    @(negedge clk);
  endtask

  task automatic setv(logic [AW-1:0] a, logic au, logic [AW-1:0] b, logic bu,
                      logic [AW-1:0] e, logic ew, logic [AW-1:0] m, logic mw);
    sa = a; sau = au; sb = b; sbu = bu; exd = e; exw = ew; memd = m; memw = mw;
  endtask

  initial begin : wd
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    ctl = 8'hA5;
    setv(5'd3, 1, 5'd3, 1, 5'd3, 1, 5'd3, 1);
    step("R9");                                // reset: no stall, ctrl flushed
    rst = 1'b0;
    ctl = 8'h3C;
    setv(5'd4, 1, 5'd7, 1, 5'd4, 1, 5'd9, 1);  step("R1");
    setv(5'd4, 1, 5'd7, 1, 5'd9, 1, 5'd7, 1);  step("R2");
    setv(5'd4, 1, 5'd7, 1, 5'd8, 1, 5'd9, 1);  step("R3");
    setv(5'd0, 1, 5'd0, 1, 5'd0, 1, 5'd0, 1);  step("R4");
    setv(5'd6, 1, 5'd6, 1, 5'd6, 0, 5'd6, 0);  step("R5");
    setv(5'd6, 0, 5'd2, 1, 5'd6, 1, 5'd6, 1);  step("R6");  // unused source matches
    setv(5'd6, 0, 5'd2, 1, 5'd2, 1, 5'd9, 0);  step("R6");  // used source matches
    ctl = 8'hFF;
    setv(5'd5, 1, 5'd5, 1, 5'd5, 1, 5'd5, 1);  step("R7");
    // R8: producer writes r10, consumer directly behind
    ctl = 8'h11;
    setv(5'd10, 1, 5'd1, 1, 5'd10, 1, 5'd12, 1); step("R8");
    if (bub) setv(5'd10, 1, 5'd1, 1, 5'd0, 0, 5'd10, 1); // bubble into EX, producer to MEM
    step("R8");
    if (bub) setv(5'd10, 1, 5'd1, 1, 5'd0, 0, 5'd0, 0);  // producer now past MEM
    step("R8");
    for (int i = 0; i < 3000; i++) begin
      setv($urandom % 4, $urandom % 2, $urandom % 4, $urandom % 2,
           $urandom % 4, $urandom % 2, $urandom % 4, $urandom % 2);
      ctl = $urandom;
      if (match(sa, sau, exd, exw) || match(sb, sbu, exd, exw)) step("R1");
      else if (exp_stall()) step("R2");
      else step("R3");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule